// File: doc/BRIEF.md
# Write Completion Status Readback

This block is the read-side logic of a byte-wide parallel non-volatile memory that reports how far an internal write has progressed. A programming controller elsewhere raises a busy flag for the whole internal write and supplies the address and value of the last byte written. The block watches the three read-side enables (select, output enable, write enable), the address presented by the host, and the data read from the backing array. It produces one registered byte and a drive flag for the data bus.

While the controller is idle, a read returns the stored byte unchanged. While a write is running, the block substitutes two status bits. The top bit of a read from the last written address comes back inverted, so a host can poll until the value it wrote appears. Bit six flips on every new read access, so a host that reads any fixed address twice can tell that the write is still going. A new access is any rise of the combined read condition, whether it comes from output enable, from select, or from both. Once the busy flag drops, the next read returns true data on all bits. Bus turn-around timing is not modelled: the drive flag is a plain registered signal.

Top module: `wcs_readback`

## Requirements
- R1: `drive_o` is 1 in the cycle after a cycle in which `sel_i`, `oe_i` and not `we_i` all hold, and 0 in the cycle after any other cycle.
- R2: Whenever `drive_o` is 0, `rd_data_o` is all zeros.
- R3: With `busy_i` low, a read returns on `rd_data_o` the `arr_data_i` value presented one cycle earlier, with no bit replaced.
- R4: With `busy_i` high and `addr_i` equal to `last_addr_i`, bit 7 of the read result is the inverse of bit 7 of `last_data_i`.
- R5: With `busy_i` high, bit 6 of the read result is an internal toggle state. That state inverts on each new read access (a cycle where the read condition holds and did not hold the cycle before, whether output enable or select caused it). It keeps its value while a read is held across cycles.
- R6: With `busy_i` high, every bit other than bit 6, and other than bit 7 at the last written address, comes from `arr_data_i`; in particular bit 7 at any other address is array data.
- R7: In the first read cycle after `busy_i` falls, all eight bits are true array data.
- R8: The toggle state is 0 after reset, so the first new access during a write reads bit 6 as 1. New accesses while `busy_i` is low leave the toggle state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Device select, active high |
| oe_i | input | 1 | Output enable, active high |
| we_i | input | 1 | Write enable, active high |
| addr_i | input | 17 | Host read address |
| arr_data_i | input | 8 | Array data for `addr_i` in the same cycle |
| busy_i | input | 1 | Internal write in progress |
| last_addr_i | input | 17 | Address of the last byte written |
| last_data_i | input | 8 | Value of the last byte written |
| rd_data_o | output | 8 | Registered read result |
| drive_o | output | 1 | Registered data bus drive enable |

## Verification
Every result of this block appears exactly one clock after the inputs that cause it. This covers the drive flag, the array pass-through, the polling bit and the toggle bit, including the toggle update caused by a new access in that same cycle. The driver changes inputs on the falling edge and pushes the predicted byte and drive flag into a queue at that moment. The monitor pops one entry a quarter period after the next rising edge, so each comparison lands in the single cycle where that result is due. The predicted toggle bit comes from a bench-side count of new accesses made while busy, so held reads, idle reads and select-caused accesses each show up in later expected values.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Where a read result bit is taken from
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

endpackage

// File: rtl/wcs_access_detect.sv
module wcs_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic oe_i,
    input  logic we_i,
    output logic acc_o,
    output logic start_o
);

    typedef struct packed {
        logic acc;
    } det_t;

    det_t st_d, st_q;
    logic acc_now;

    always_comb begin
        acc_now    = sel_i & oe_i & ~we_i;
        st_d       = st_q;
        st_d.acc   = acc_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o   = acc_now;
    assign start_o = acc_now & ~st_q.acc;

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    output logic tog_nxt_o
);

    typedef struct packed {
        logic tog;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i && busy_i) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog_nxt_o = st_d.tog;

    // R5
    flip_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_i) |=> (st_q.tog != $past(st_q.tog)));

    // R8
    hold_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && busy_i) |=> $stable(st_q.tog));

endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
    import wcs_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TOG_BIT  = DATA_W - 2
) (
    input  logic              acc_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] last_data_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              tog_nxt_i,
    output logic [DATA_W-1:0] data_nxt_o
);

    logic     hit;
    rd_src_e  src_poll, src_tog, src_rest;

    always_comb begin
        hit      = (addr_i == last_addr_i);
        src_rest = acc_i ? SRC_ARRAY : SRC_NONE;
        src_tog  = (acc_i && busy_i) ? SRC_STATUS : src_rest;
        src_poll = (acc_i && busy_i && hit) ? SRC_STATUS : src_rest;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        rd_src_e src;
        logic    status_val;
        if (b == POLL_BIT) begin : g_poll
            assign src        = src_poll;
            assign status_val = ~last_data_i[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign src        = src_tog;
            assign status_val = tog_nxt_i;
        end else begin : g_plain
            assign src        = src_rest;
            assign status_val = 1'b0;
        end
        always_comb begin
            case (src)
                SRC_ARRAY:  data_nxt_o[b] = arr_data_i[b];
                SRC_STATUS: data_nxt_o[b] = status_val;
                default:    data_nxt_o[b] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wcs_readback.sv
module wcs_readback #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              oe_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] last_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              drive_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_t;

    logic              acc, start, tog_nxt;
    logic [DATA_W-1:0] data_nxt;
    out_t              out_d, out_q;

    wcs_access_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel_i),
        .oe_i    (oe_i),
        .we_i    (we_i),
        .acc_o   (acc),
        .start_o (start)
    );

    wcs_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .busy_i    (busy_i),
        .tog_nxt_o (tog_nxt)
    );

    wcs_status_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .acc_i       (acc),
        .busy_i      (busy_i),
        .addr_i      (addr_i),
        .last_addr_i (last_addr_i),
        .last_data_i (last_data_i),
        .arr_data_i  (arr_data_i),
        .tog_nxt_i   (tog_nxt),
        .data_nxt_o  (data_nxt)
    );

    always_comb begin
        out_d       = out_q;
        out_d.drive = acc;
        out_d.data  = data_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data_o = out_q.data;
    assign drive_o   = out_q.drive;

    // R1
    drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && oe_i && !we_i) |=> drive_o);

    // R1
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && oe_i && !we_i) |=> !drive_o);

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (rd_data_o == '0));

    // R3
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && oe_i && !we_i && !busy_i) |=> (rd_data_o == $past(arr_data_i)));

    // R4
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && oe_i && !we_i && busy_i && addr_i == last_addr_i)
        |=> (rd_data_o[POLL_BIT] == ~$past(last_data_i[POLL_BIT])));

endmodule

// File: tb/wcs_readback_test.sv
module wcs_readback_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, oe_i = 1'b0, we_i = 1'b0, busy_i = 1'b0;
    logic [16:0] addr_i = '0, last_addr_i = '0;
    logic [7:0]  arr_data_i, last_data_i = '0;
    logic [7:0]  rd_data_o;
    logic        drive_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] data;
        logic       drv;
        string      tag;
    } exp_t;

    exp_t sb[$];
    logic tb_tog  = 1'b0;
    logic tb_prev = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_of(input logic [16:0] a);
        return a[7:0] ^ {a[16:13], a[12:9]} ^ 8'h5A;
    endfunction

    assign arr_data_i = mem_of(addr_i);

    wcs_readback uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .oe_i(oe_i), .we_i(we_i),
        .addr_i(addr_i), .arr_data_i(arr_data_i), .busy_i(busy_i),
        .last_addr_i(last_addr_i), .last_data_i(last_data_i),
        .rd_data_o(rd_data_o), .drive_o(drive_o)
    );

    task automatic step(input logic s, input logic o, input logic w,
                        input logic [16:0] a, input logic b, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        sel_i = s; oe_i = o; we_i = w; addr_i = a; busy_i = b;
        acc = s & o & ~w;
        if (acc && !tb_prev && b) tb_tog = ~tb_tog;
        tb_prev = acc;
        e.tag = tag;
        e.drv = acc;
        if (!acc) e.data = 8'h00;
        else begin
            e.data = mem_of(a);
            if (b) begin
                e.data[6] = tb_tog;
                if (a == last_addr_i) e.data[7] = ~last_data_i[7];
            end
        end
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            tests++;
            if (rd_data_o !== e.data || drive_o !== e.drv) begin
                fails++;
                $display("FAIL %s: data=%h drive=%b expected data=%h drive=%b",
                         e.tag, rd_data_o, drive_o, e.data, e.drv);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [16:0] la;
        la = 17'h0_1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R1 reset state
        tests++;
        if (rd_data_o !== 8'h00 || drive_o !== 1'b0) begin
            fails++;
            $display("FAIL R1/R2 reset: data=%h drive=%b expected data=00 drive=0",
                     rd_data_o, drive_o);
        end

        // R3 idle array reads, address walk under a held read
        for (int i = 0; i < 6; i++) step(1, 1, 0, 17'h0_0100 + 17'(i * 37), 0, "R3 idle read");
        // R1 R2 bus released: write enable, no select, no output enable
        step(1, 1, 1, 17'h0_0003, 0, "R1 we blocks read");
        step(0, 1, 0, 17'h0_0003, 0, "R2 no select");
        step(1, 0, 0, 17'h0_0003, 0, "R2 no output enable");
        // R8 idle new accesses leave toggle alone
        step(1, 1, 0, 17'h0_0004, 0, "R8 idle access");
        step(1, 0, 0, 17'h0_0004, 0, "R8 idle gap");
        step(1, 1, 0, 17'h0_0004, 0, "R8 idle access 2");

        // Write starts
        @(negedge clk);
        last_addr_i = la;
        last_data_i = 8'h3C;
        step(0, 0, 0, la, 1, "R2 busy no read");
        // R8 first access reads bit 6 as 1; R4 bit 7 inverted
        step(1, 1, 0, la, 1, "R4 R8 first poll");
        // R5 held read keeps toggle
        step(1, 1, 0, la, 1, "R5 held read");
        step(1, 1, 0, la, 1, "R5 held read 2");
        // R5 output enable caused accesses
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, la, 1, "R5 oe gap");
            step(1, 1, 0, la, 1, "R5 oe access");
        end
        // R5 select caused accesses
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, la, 1, "R5 sel gap");
            step(1, 1, 0, la, 1, "R5 sel access");
        end
        // R4 with top bit set in last data
        @(negedge clk);
        last_data_i = 8'hA5;
        step(1, 0, 0, la, 1, "R4 gap");
        step(1, 1, 0, la, 1, "R4 top bit set");
        // R6 other addresses: bit 7 from array, bit 6 toggles
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 17'h1_0F00 + 17'(i), 1, "R6 gap");
            step(1, 1, 0, 17'h1_0F00 + 17'(i), 1, "R6 other address");
        end
        // R7 busy falls during a held read
        step(1, 1, 0, la, 1, "R4 before end");
        step(1, 1, 0, la, 0, "R7 first idle read");
        step(1, 1, 0, la, 0, "R7 idle read");
        // R8 idle accesses do not move toggle, checked on next write
        step(1, 0, 0, la, 0, "R8 idle gap");
        step(1, 1, 0, la, 0, "R8 idle access");
        step(1, 0, 0, la, 1, "R8 busy gap");
        step(1, 1, 0, la, 1, "R8 toggle continued");
        step(0, 0, 0, la, 0, "R1 release");
        step(0, 0, 0, la, 0, "R2 quiet");

        repeat (3) @(posedge clk);
        #6;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule